// File: doc/BRIEF.md
# Cross-Lane Data Permutation Unit

This unit moves 32-bit values between the lanes of one wavefront of 64 lanes, or of 32 lanes when the wave-size select is set. Every output lane takes its value from another lane, chosen by a mode code and an 8-bit argument. The lanes form rows of 16. Each row is split into four banks of 4 consecutive lanes. The modes are quad crossbars, row-local shifts, rotates and mirrors, whole-wave shifts and rotates by one lane, and broadcasts from the last lane of a row into later rows.

The permuted value does not always reach the output. A lane whose row or bank is disabled by the two enable masks keeps its fallback ("old") value. A lane whose source lies outside its row, or outside the wave, is an out-of-bounds lane. It takes either old or zero, depending on the zero-fill flag. Lanes that a mode does not touch, illegal arguments and unknown mode codes also keep old.

The caller presents both lane vectors and the controls with a one-cycle valid strobe. The merged result is registered and appears with a valid flag one clock later. The result then holds until the next strobe.

Top module: `lane_xchg_unit`

## Requirements
- R1: Mode 0 (quad crossbar): lane 4k+i outputs the source of lane 4k+s, where s = arg[2i+1:2i].
- R2: Modes 1 and 2 (row shift up / down by c = arg[3:0]): lane n reads row position (n mod 16)+c or (n mod 16)-c of its own row. A position outside 0..15 makes the lane out of bounds.
- R3: Mode 3 (row rotate): lane n reads row position ((n mod 16)-c) mod 16 and is never out of bounds.
- R4: Modes 4..7 (wave forward shift, wave backward shift, wave rotate forward, wave rotate backward): lane n reads n+1, n-1, (n+1) mod 64 and (n-1) mod 64 respectively. For the two shifts, lane 63 and lane 0 respectively are out of bounds.
- R5: Mode 8 reads row position 15-(n mod 16). Mode 9 reads position 7-(n mod 8) within the lane's 8-lane half row.
- R6: Mode 10 copies lane 16r-1 to every lane of row r for r >= 1, and row 0 keeps old. Mode 11 copies lane 31 to every lane of rows 2 and 3, and rows 0 and 1 keep old.
- R7: row_en[r] = 0 makes every lane of row r output old, in every mode.
- R8: bank_en[b] = 0 makes lanes 4b..4b+3 of every row output old, in every mode.
- R9: An out-of-bounds lane outputs old when zero_oob = 0 and zero when zero_oob = 1. Masking takes precedence over this rule.
- R10: res_lanes and out_valid update on the clock edge that samples in_valid = 1, with out_valid high for exactly that one cycle. Without a strobe, out_valid is 0 and res_lanes holds.
- R11: With wave32 = 1, modes 4..7, 10 and 11 output old, and lanes 32..63 output zero in every mode.
- R12: Mode codes 12..15, and modes 1..3 with arg[3:0] = 0, output old on every active lane.
- R13: While rst_n is low, out_valid and res_lanes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| wave32 | input | 1 | 1 selects a 32-lane wave |
| mode | input | 4 | Permutation mode code |
| arg | input | 8 | Mode argument (quad selectors or shift count) |
| row_en | input | 4 | Per-row write enable |
| bank_en | input | 4 | Per-bank write enable, applied in every row |
| zero_oob | input | 1 | Out-of-bounds lanes output zero when set |
| src_lanes | input | 2048 | Source value of each lane, lane n at bits 32n+31:32n |
| old_lanes | input | 2048 | Fallback value of each lane |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| res_lanes | output | 2048 | Merged result lanes |

## Verification
The mask merge and the out-of-bounds rule can both claim the same lane in the same operation. This happens when a shift pushes a lane's source outside its row and that lane's row or bank is also disabled. It is provoked by a row shift down by one with row_en = 4'h5 and zero_oob set. The position-0 lanes of rows 1 and 3 are then both disabled and out of bounds. The bench expects old on those lanes and zero on the position-0 lanes of rows 0 and 2. A bank-masked rotate and a row-masked half mirror cover the same precedence for the in-bounds modes.

// File: rtl/lxu_pkg.sv
package lxu_pkg;
  localparam int MODE_W = 4;
  localparam int ARG_W  = 8;

  typedef enum logic [MODE_W-1:0] {
    MD_QUAD = 4'd0,
    MD_RSHL = 4'd1,
    MD_RSHR = 4'd2,
    MD_RROR = 4'd3,
    MD_WSHL = 4'd4,
    MD_WSHR = 4'd5,
    MD_WROL = 4'd6,
    MD_WROR = 4'd7,
    MD_RMIR = 4'd8,
    MD_HMIR = 4'd9,
    MD_BC15 = 4'd10,
    MD_BC31 = 4'd11
  } lxu_mode_e;

  // What a lane does with its selected source.
  typedef enum logic [1:0] {
    PK_SRC = 2'd0,
    PK_OOB = 2'd1,
    PK_OLD = 2'd2
  } lxu_pick_e;
endpackage

// File: rtl/lxu_route.sv
module lxu_route
  import lxu_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ROW_W  = 16,
  localparam int IDXW  = $clog2(LANES),
  localparam int CNTW  = $clog2(ROW_W)
) (
  input  logic [MODE_W-1:0]            mode_i,
  input  logic [ARG_W-1:0]             arg_i,
  input  logic                         wave32_i,
  output logic [LANES-1:0][IDXW-1:0]   idx_o,
  output logic [LANES-1:0][1:0]        pick_o
);
  localparam int QUAD  = 4;
  localparam int HALFR = ROW_W / 2;

  logic [CNTW-1:0] cnt;
  assign cnt = arg_i[CNTW-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int POS   = g % ROW_W;
    localparam int BASE  = g - POS;
    localparam int ROWN  = g / ROW_W;
    localparam int HPOS  = g % HALFR;
    localparam int QPOS  = g % QUAD;
    localparam int QBASE = g - QPOS;
    localparam bit FIRST = (g == 0);
    localparam bit LAST  = (g == LANES - 1);
    localparam bit ROW0  = (ROWN == 0);
    localparam bit LOW2  = (ROWN < 2);

    logic [CNTW:0]   up_pos;
    logic [CNTW:0]   dn_pos;
    logic [IDXW-1:0] lane_idx;
    logic [1:0]      lane_pick;

    always_comb begin
      up_pos    = (CNTW+1)'(POS) + (CNTW+1)'(cnt);
      dn_pos    = (CNTW+1)'(POS) - (CNTW+1)'(cnt);
      lane_idx  = IDXW'(g);
      lane_pick = PK_SRC;
      case (mode_i)
        MD_QUAD: lane_idx = IDXW'(QBASE) + IDXW'(arg_i[2*QPOS +: 2]);
        MD_RSHL: begin
          if (cnt == '0)       lane_pick = PK_OLD;
          else if (up_pos[CNTW]) lane_pick = PK_OOB;
          else lane_idx = IDXW'(BASE) + IDXW'(up_pos[CNTW-1:0]);
        end
        MD_RSHR: begin
          if (cnt == '0)       lane_pick = PK_OLD;
          else if (dn_pos[CNTW]) lane_pick = PK_OOB;
          else lane_idx = IDXW'(BASE) + IDXW'(dn_pos[CNTW-1:0]);
        end
        MD_RROR: begin
          if (cnt == '0) lane_pick = PK_OLD;
          else lane_idx = IDXW'(BASE) + IDXW'(dn_pos[CNTW-1:0]);
        end
        MD_WSHL: begin
          if (wave32_i)  lane_pick = PK_OLD;
          else if (LAST) lane_pick = PK_OOB;
          else           lane_idx  = IDXW'((g + 1) % LANES);
        end
        MD_WSHR: begin
          if (wave32_i)   lane_pick = PK_OLD;
          else if (FIRST) lane_pick = PK_OOB;
          else            lane_idx  = IDXW'((g + LANES - 1) % LANES);
        end
        MD_WROL: begin
          if (wave32_i) lane_pick = PK_OLD;
          else          lane_idx  = IDXW'((g + 1) % LANES);
        end
        MD_WROR: begin
          if (wave32_i) lane_pick = PK_OLD;
          else          lane_idx  = IDXW'((g + LANES - 1) % LANES);
        end
        MD_RMIR: lane_idx = IDXW'(BASE + ROW_W - 1 - POS);
        MD_HMIR: lane_idx = IDXW'(g - HPOS + HALFR - 1 - HPOS);
        MD_BC15: begin
          if (wave32_i || ROW0) lane_pick = PK_OLD;
          else                  lane_idx  = IDXW'((BASE + LANES - 1) % LANES);
        end
        MD_BC31: begin
          if (wave32_i || LOW2) lane_pick = PK_OLD;
          else                  lane_idx  = IDXW'(2 * ROW_W - 1);
        end
        default: lane_pick = PK_OLD;
      endcase
    end

    assign idx_o[g]  = lane_idx;
    assign pick_o[g] = lane_pick;
  end
endmodule

// File: rtl/lxu_merge.sv
module lxu_merge
  import lxu_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int DW     = 32,
  parameter int ROW_W  = 16,
  parameter int BANK_W = 4,
  localparam int IDXW  = $clog2(LANES),
  localparam int NROWS = LANES / ROW_W,
  localparam int NBANK = ROW_W / BANK_W
) (
  input  logic [LANES*DW-1:0]          src_i,
  input  logic [LANES*DW-1:0]          old_i,
  input  logic [LANES-1:0][IDXW-1:0]   idx_i,
  input  logic [LANES-1:0][1:0]        pick_i,
  input  logic [NROWS-1:0]             row_en_i,
  input  logic [NBANK-1:0]             bank_en_i,
  input  logic                         zero_oob_i,
  input  logic                         wave32_i,
  output logic [LANES*DW-1:0]          res_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int  ROWN  = g / ROW_W;
    localparam int  BANKN = (g % ROW_W) / BANK_W;
    localparam bit  UPPER = (g >= LANES / 2);

    logic [DW-1:0] fetched;
    logic [DW-1:0] own_old;
    logic [DW-1:0] lane_out;

    always_comb begin
      fetched = src_i[int'(idx_i[g])*DW +: DW];
      own_old = old_i[g*DW +: DW];
      if (UPPER && wave32_i) begin
        lane_out = '0;
      end else if (!row_en_i[ROWN] || !bank_en_i[BANKN]) begin
        lane_out = own_old;
      end else begin
        case (pick_i[g])
          PK_SRC:  lane_out = fetched;
          PK_OOB:  lane_out = zero_oob_i ? '0 : own_old;
          default: lane_out = own_old;
        endcase
      end
    end

    assign res_o[g*DW +: DW] = lane_out;
  end
endmodule

// File: rtl/lane_xchg_unit.sv
module lane_xchg_unit
  import lxu_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int DW     = 32,
  parameter int ROW_W  = 16,
  parameter int BANK_W = 4,
  localparam int NROWS = LANES / ROW_W,
  localparam int NBANK = ROW_W / BANK_W,
  localparam int IDXW  = $clog2(LANES),
  localparam int VECW  = LANES * DW,
  localparam int HALFW = VECW / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              wave32,
  input  logic [MODE_W-1:0] mode,
  input  logic [ARG_W-1:0]  arg,
  input  logic [NROWS-1:0]  row_en,
  input  logic [NBANK-1:0]  bank_en,
  input  logic              zero_oob,
  input  logic [VECW-1:0]   src_lanes,
  input  logic [VECW-1:0]   old_lanes,
  output logic              out_valid,
  output logic [VECW-1:0]   res_lanes
);
  logic [LANES-1:0][IDXW-1:0] sel_idx;
  logic [LANES-1:0][1:0]      sel_pick;
  logic [VECW-1:0]            merged;

  lxu_route #(.LANES(LANES), .ROW_W(ROW_W)) u_route (
    .mode_i   (mode),
    .arg_i    (arg),
    .wave32_i (wave32),
    .idx_o    (sel_idx),
    .pick_o   (sel_pick)
  );

  lxu_merge #(.LANES(LANES), .DW(DW), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_merge (
    .src_i      (src_lanes),
    .old_i      (old_lanes),
    .idx_i      (sel_idx),
    .pick_i     (sel_pick),
    .row_en_i   (row_en),
    .bank_en_i  (bank_en),
    .zero_oob_i (zero_oob),
    .wave32_i   (wave32),
    .res_o      (merged)
  );

  // Next state
  logic            vld_d, res_en;
  logic [VECW-1:0] res_d;
  logic            vld_q;
  logic [VECW-1:0] res_q;

  always_comb begin
    vld_d  = in_valid;
    res_en = in_valid;
    res_d  = merged;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign res_lanes = res_q;

  // Timing of the result register
  assert_strobe_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("assert_strobe_lat_R10");

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res_lanes)))
    else $error("assert_hold_R10");

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(wave32)) |-> (res_lanes[VECW-1:HALFW] == '0))
    else $error("assert_upper_zero_R11");

  assert_unknown_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(mode) > 4'd11)) |->
      (res_lanes[HALFW-1:0] == $past(old_lanes[HALFW-1:0])))
    else $error("assert_unknown_mode_R12");

  for (genvar r = 0; r < NROWS; r++) begin : g_row_chk
    localparam bit HI = (r >= NROWS / 2);
    assert_row_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(row_en[r]) && !(HI && $past(wave32))) |->
        (res_lanes[r*ROW_W*DW +: ROW_W*DW] == $past(old_lanes[r*ROW_W*DW +: ROW_W*DW])))
      else $error("assert_row_mask_R7 row %0d", r);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
      localparam int OFS = (r * ROW_W + b * BANK_W) * DW;
      assert_bank_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(bank_en[b]) && !(HI && $past(wave32))) |->
          (res_lanes[OFS +: BANK_W*DW] == $past(old_lanes[OFS +: BANK_W*DW])))
        else $error("assert_bank_mask_R8 row %0d bank %0d", r, b);
    end
  end
endmodule

// File: tb/lane_xchg_unit_tb.sv
`timescale 1ns/1ps
module lane_xchg_unit_tb;
  localparam int L = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, wave32, zero_oob;
  logic [3:0] mode, row_en, bank_en;
  logic [7:0] arg;
  logic [L*32-1:0] src_lanes, old_lanes;
  logic out_valid;
  logic [L*32-1:0] res_lanes;

  always #2.5 clk = ~clk;

  lane_xchg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wave32(wave32),
    .mode(mode), .arg(arg), .row_en(row_en), .bank_en(bank_en),
    .zero_oob(zero_oob), .src_lanes(src_lanes), .old_lanes(old_lanes),
    .out_valid(out_valid), .res_lanes(res_lanes)
  );

  typedef struct packed {
    logic [3:0] mode;
    logic [7:0] arg;
    logic [3:0] re;
    logic [3:0] be;
    logic       zo;
    logic       w32;
    logic       pat;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{4'd0,  8'hB1, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R1 pair swap 1,0,3,2
    '{4'd0,  8'h4F, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1}, // R1 selectors 3,3,0,1
    '{4'd1,  8'h01, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R2 R9 keep old
    '{4'd1,  8'h0F, 4'hF, 4'hF, 1'b1, 1'b0, 1'b1}, // R2 R9 zero fill
    '{4'd2,  8'h01, 4'h5, 4'hF, 1'b1, 1'b0, 1'b0}, // R2 R7 R9 mask beats oob
    '{4'd2,  8'h07, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1}, // R2
    '{4'd3,  8'h05, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd3,  8'hFF, 4'hF, 4'hA, 1'b1, 1'b0, 1'b1}, // R3 R8
    '{4'd4,  8'h00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R4 R9
    '{4'd5,  8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1}, // R4 R9
    '{4'd6,  8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd7,  8'h00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b1}, // R4
    '{4'd8,  8'h00, 4'hF, 4'hF, 1'b0, 1'b0, 1'b0}, // R5
    '{4'd9,  8'h00, 4'h9, 4'hF, 1'b0, 1'b0, 1'b1}, // R5 R7
    '{4'd10, 8'h00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd11, 8'h00, 4'hF, 4'h6, 1'b1, 1'b0, 1'b1}, // R6 R8
    '{4'd1,  8'h03, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0}, // R11 row mode in 32 lanes
    '{4'd6,  8'h00, 4'hF, 4'hF, 1'b0, 1'b1, 1'b1}, // R11 wave mode off
    '{4'd10, 8'h00, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0}, // R11 broadcast off
    '{4'd1,  8'h00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b1}, // R12 zero count
    '{4'd3,  8'h10, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R12 zero count in low bits
    '{4'd12, 8'h00, 4'hF, 4'hF, 1'b1, 1'b0, 1'b0}, // R12 unknown code
    '{4'd15, 8'h00, 4'hF, 4'hF, 1'b1, 1'b1, 1'b1}, // R12 R11 unknown code, 32 lanes
    '{4'd0,  8'hE4, 4'h0, 4'hF, 1'b0, 1'b0, 1'b0}  // R7 all rows disabled
  };

  logic [31:0] s_arr [L];
  logic [31:0] o_arr [L];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic void load_pattern(logic p);
    for (int n = 0; n < L; n++) begin
      s_arr[n] = 32'hA000_0000 + (p ? 32'h0050_0000 : 32'h0) + n * 32'h0001_0101;
      o_arr[n] = 32'h0B00_0000 + (p ? 32'h0000_7000 : 32'h0) + n * 3 + 1;
      src_lanes[n*32 +: 32] = s_arr[n];
      old_lanes[n*32 +: 32] = o_arr[n];
    end
  endfunction

  function automatic logic [31:0] model(int n, vec_t v);
    int wsz  = v.w32 ? 32 : 64;
    int row  = n / 16;
    int bank = (n % 16) / 4;
    int pos  = n % 16;
    int base = n - pos;
    int cnt  = int'(v.arg[3:0]);
    int s    = n;
    bit oob  = 1'b0;
    bit keep = 1'b0;
    if (n >= wsz) return 32'h0;
    if (!v.re[row] || !v.be[bank]) return o_arr[n];
    case (int'(v.mode))
      0: s = (n / 4) * 4 + int'((v.arg >> (2 * (n % 4))) & 8'd3);
      1: if (cnt == 0) keep = 1; else if (pos + cnt > 15) oob = 1; else s = base + pos + cnt;
      2: if (cnt == 0) keep = 1; else if (pos - cnt < 0) oob = 1; else s = base + pos - cnt;
      3: if (cnt == 0) keep = 1; else s = base + (pos - cnt + 16) % 16;
      4: if (v.w32) keep = 1; else if (n == wsz - 1) oob = 1; else s = n + 1;
      5: if (v.w32) keep = 1; else if (n == 0) oob = 1; else s = n - 1;
      6: if (v.w32) keep = 1; else s = (n + 1) % wsz;
      7: if (v.w32) keep = 1; else s = (n + wsz - 1) % wsz;
      8: s = base + 15 - pos;
      9: s = (n / 8) * 8 + 7 - (n % 8);
      10: if (v.w32 || row == 0) keep = 1; else s = row * 16 - 1;
      11: if (v.w32 || row < 2) keep = 1; else s = 31;
      default: keep = 1;
    endcase
    if (keep) return o_arr[n];
    if (oob) return v.zo ? 32'h0 : o_arr[n];
    return s_arr[s];
  endfunction

  function automatic string tag_of(vec_t v);
    string t;
    case (int'(v.mode))
      0: t = "R1";
      1, 2: t = "R2";
      3: t = "R3";
      4, 5, 6, 7: t = "R4";
      8, 9: t = "R5";
      10, 11: t = "R6";
      default: t = "R12";
    endcase
    if (v.w32) t = {t, "/R11"};
    if (v.re != 4'hF) t = {t, "/R7"};
    if (v.be != 4'hF) t = {t, "/R8"};
    if (v.zo) t = {t, "/R9"};
    return t;
  endfunction

  task automatic drive(vec_t v);
    load_pattern(v.pat);
    mode = v.mode; arg = v.arg; row_en = v.re; bank_en = v.be;
    zero_oob = v.zo; wave32 = v.w32;
  endtask

  task automatic compare_all(vec_t v, string tag);
    int bad = -1;
    checks++;
    for (int n = 0; n < L; n++)
      if (bad < 0 && res_lanes[n*32 +: 32] !== model(n, v)) bad = n;
    if (!out_valid || bad >= 0) begin
      errors++;
      if (bad < 0) bad = 0;
      $display("FAIL %s lane %0d valid %0b act %h exp %h", tag, bad, out_valid,
               res_lanes[bad*32 +: 32], model(bad, v));
    end
  endtask

  // One strobe: inputs at a falling edge, result sampled one falling edge later.
  task automatic run_vec(vec_t v);
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare_all(v, tag_of(v));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [L*32-1:0] snap;
    rst_n = 1'b0; in_valid = 1'b0;
    drive(TBL[0]);
    repeat (3) @(negedge clk);
    // R13 reset state
    checks++;
    if (out_valid !== 1'b0 || res_lanes !== '0) begin
      errors++;
      $display("FAIL R13 reset valid %0b act %h exp 0", out_valid, res_lanes[31:0]);
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R10: no strobe, changed inputs -> valid low, result held
    snap = res_lanes;
    @(negedge clk);
    drive(TBL[6]);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || res_lanes !== snap) begin
      errors++;
      $display("FAIL R10 hold valid %0b act %h exp %h", out_valid, res_lanes[31:0], snap[31:0]);
    end

    // R10: back-to-back strobes, each result one cycle after its own strobe
    @(negedge clk);
    drive(TBL[12]); in_valid = 1'b1;
    @(negedge clk);
    compare_all(TBL[12], "R10/R5 first of pair");
    drive(TBL[10]); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare_all(TBL[10], "R10/R4 second of pair");
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 single-cycle valid act %0b exp 0", out_valid);
    end

    // R13: reset clears a held result
    rst_n = 1'b0;
    #1;
    checks++;
    if (out_valid !== 1'b0 || res_lanes !== '0) begin
      errors++;
      $display("FAIL R13 mid-run reset act %h exp 0", res_lanes[31:0]);
    end
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(TBL[4]); // R9 R7 after reset

    finish_run();
  end
endmodule